// File: doc/BRIEF.md
# Randomized Subwarp Memory Coalescer

The block takes one warp-wide memory instruction (one 32-bit address for each lane and a mask of active lanes) and turns it into a stream of cache-line requests. Each request carries a line address (the byte address without its low `LINE_BITS` bits) and the mask of the lanes that it serves. Lanes are merged only when they fall in the same line *and* belong to the same subwarp. The lanes are divided into subwarps in one of three ways, and a built-in pseudo-random generator drives two of them. As a result, the number of requests depends on a per-instruction random partition and not only on the access pattern.

An instruction is accepted through a valid/ready handshake. Requests leave through a second valid/ready handshake, one for each accepted cycle. A one-cycle `done` pulse follows the handoff of the last request. The partition mode, the subwarp size and the generator state are sampled on the cycle that the instruction is accepted. A seed input makes the random sequence reproducible.

Top module: `rsw_coalescer`

## Requirements
- R1: Active lanes of one subwarp whose addresses share bits [31:7] are served by exactly one request. Its `out_line` equals those bits, and its `out_lanes` bit i is set for every such lane i.
- R2: Lanes in different subwarps never share a request, even when they touch the same line. With all 32 lanes on one line in fixed mode, exactly 32 >> size_log requests appear.
- R3: Mode 0 (and the spare code 3) cuts the lanes into contiguous subwarps of 2^`cfg_size_log` lanes, with values above 5 treated as 5. Lane i belongs to the group starting at i rounded down to that size.
- R4: Mode 1 splits the warp with a binary tree whose nodes are numbered in heap order (root 0, children 2k+1 and 2k+2, the lower lanes in child 2k+1). Node k is split when generator bit (k mod 16) is 1 and its parent was split. Each leaf block is one subwarp, so the sizes are powers of two that sum to 32.
- R5: Mode 2 places lane i at position ((i XOR s[13:9]) * (2*s[3:0]+1) + s[8:4]) mod 32, where s is the generator state. Consecutive runs of 2^`cfg_size_log` positions form the subwarps.
- R6: The generator is a 16-bit right-shifting Galois LFSR with feedback mask 0xB400 and reset value 0xACE1. `seed_load` loads `seed_value`, and a zero seed loads 0x0001. The generator advances exactly once for each accepted instruction, and the partition uses the state from before that advance.
- R7: An inactive lane never appears in any `out_lanes`. An instruction with an all-zero active mask produces no request, and `done` is high on the cycle after its acceptance.
- R8: Requests come out in increasing order of subwarp start (lowest lane for mode 0 and mode 1, lowest position for mode 2). Inside a subwarp they come out in increasing order of the lowest lane that they serve.
- R9: While `out_valid` is high and `out_ready` is low, `out_line` and `out_lanes` hold. `in_ready` stays low until the last request has been handed off. `done` is high only on the cycle after the last handoff and is low while requests remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Partition mode: 0 fixed, 1 random size, 2 random membership, 3 as 0 |
| cfg_size_log | input | 3 | log2 of the subwarp size for modes 0, 2 and 3 |
| seed_load | input | 1 | Loads the generator from seed_value |
| seed_value | input | 16 | Generator seed |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block is idle and takes an instruction |
| in_addr | input | 1024 | Lane addresses, lane i at bits [32i+31:32i] |
| in_active | input | 32 | Active lane mask |
| out_valid | output | 1 | Request offered |
| out_ready | input | 1 | Request taken |
| out_line | output | 25 | Line address of the request |
| out_lanes | output | 32 | Lanes served by the request |
| done | output | 1 | One-cycle pulse after the last request of an instruction |

## Verification
The first request of an instruction appears in the cycle that follows the accepting clock edge. Each later request appears in the cycle after the edge that hands off the previous one. `done` rises after the edge of the last handoff, or after the accepting edge when the mask is empty. The bench drives and samples on falling edges, so each request is compared exactly one edge after the handshake that produced it, and a stall is confirmed one edge later. It sweeps every mode, every subwarp size and several address and mask patterns. A bench-side LFSR and partition model, built from the formulas in the requirements, supplies the expected request list.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
   typedef enum logic [1:0] {
      MODE_FIXED   = 2'd0,
      MODE_RSIZE   = 2'd1,
      MODE_RTHREAD = 2'd2,
      MODE_SPARE   = 2'd3
   } rsw_mode_e;
endpackage

// File: rtl/rsw_lfsr.sv
module rsw_lfsr #(
   parameter int           W         = 16,
   parameter logic [W-1:0] TAPS      = 16'hB400,
   parameter logic [W-1:0] RESET_VAL = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] seed,
   output logic [W-1:0] state
);
   if (RESET_VAL == '0) begin : g_bad_reset
      $error("rsw_lfsr: reset value must be nonzero");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state <= RESET_VAL;
      else if (load)
         state <= (seed == '0) ? W'(1) : seed;
      else if (step)
         state <= (state >> 1) ^ (state[0] ? TAPS : '0);
   end
endmodule

// File: rtl/rsw_partition.sv
module rsw_partition
   import rsw_pkg::*;
#(
   parameter int LANES  = 32,
   parameter int SEED_W = 16,
   localparam int LANE_W = $clog2(LANES),
   localparam int SZ_W   = $clog2(LANE_W + 1)
) (
   input  rsw_mode_e                     mode,
   input  logic [SZ_W-1:0]               size_log,
   input  logic [SEED_W-1:0]             rnd,
   output logic [LANES-1:0][LANE_W-1:0]  gid
);
   function automatic int blk_start(int pos, int sl);
      return pos & ~((1 << sl) - 1);
   endfunction

   function automatic int tree_start(int lane, logic [SEED_W-1:0] s);
      int node, span, start;
      logic go;
      node  = 0;
      span  = LANES;
      start = 0;
      go    = 1'b1;
      for (int k = 0; k < LANE_W; k++) begin
         if (go && s[node % SEED_W]) begin
            span = span / 2;
            if (lane >= start + span) begin
               start = start + span;
               node  = 2 * node + 2;
            end else begin
               node  = 2 * node + 1;
            end
         end else begin
            go = 1'b0;
         end
      end
      return start;
   endfunction

   int slc, mul, off, flip, g;

   always_comb begin
      slc  = (int'(size_log) > LANE_W) ? LANE_W : int'(size_log);
      mul  = ((int'(rnd) & 15) << 1) | 1;
      off  = (int'(rnd) >> 4) & (LANES - 1);
      flip = (int'(rnd) >> 9) & (LANES - 1);
      g    = 0;
      for (int l = 0; l < LANES; l++) begin
         case (mode)
            MODE_RSIZE:   g = tree_start(l, rnd);
            MODE_RTHREAD: g = blk_start((((l ^ flip) * mul) + off) & (LANES - 1), slc);
            default:      g = blk_start(l, slc);
         endcase
         gid[l] = g[LANE_W-1:0];
      end
   end
endmodule

// File: rtl/rsw_select.sv
module rsw_select #(
   parameter int LANES  = 32,
   parameter int LINE_W = 25,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic [LANES-1:0]              pend,
   input  logic [LANES-1:0][LANE_W-1:0]  gid,
   input  logic [LANES-1:0][LINE_W-1:0]  line,
   output logic [LANES-1:0]              lanes,
   output logic [LINE_W-1:0]             sel_line
);
   logic [LANES-1:0]  grp_live;
   logic [LANES-1:0]  in_grp;
   logic [LANE_W-1:0] grp;
   logic [LANE_W-1:0] leader;
   logic              found;
   logic              got_lead;

   always_comb begin
      grp_live = '0;
      for (int l = 0; l < LANES; l++)
         if (pend[l]) grp_live[gid[l]] = 1'b1;

      grp   = '0;
      found = 1'b0;
      for (int k = 0; k < LANES; k++)
         if (!found && grp_live[k]) begin
            grp   = LANE_W'(k);
            found = 1'b1;
         end

      leader   = '0;
      got_lead = 1'b0;
      for (int l = 0; l < LANES; l++) begin
         in_grp[l] = pend[l] && (gid[l] == grp);
         if (in_grp[l] && !got_lead) begin
            leader   = LANE_W'(l);
            got_lead = 1'b1;
         end
      end

      sel_line = line[leader];
      for (int l = 0; l < LANES; l++)
         lanes[l] = in_grp[l] && (line[l] == sel_line);
   end
endmodule

// File: rtl/rsw_coalescer.sv
module rsw_coalescer
   import rsw_pkg::*;
#(
   parameter int LANES     = 32,
   parameter int ADDR_W    = 32,
   parameter int LINE_BITS = 7,
   parameter int SEED_W    = 16,
   localparam int LANE_W   = $clog2(LANES),
   localparam int SZ_W     = $clog2(LANE_W + 1),
   localparam int LINE_W   = ADDR_W - LINE_BITS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              cfg_mode,
   input  logic [SZ_W-1:0]         cfg_size_log,
   input  logic                    seed_load,
   input  logic [SEED_W-1:0]       seed_value,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [LANES*ADDR_W-1:0] in_addr,
   input  logic [LANES-1:0]        in_active,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [LINE_W-1:0]       out_line,
   output logic [LANES-1:0]        out_lanes,
   output logic                    done
);
   if (LANES < 2 || LANES > 32 || LANES != (1 << LANE_W)) begin : g_bad_lanes
      $error("rsw_coalescer: LANES must be a power of two from 2 to 32");
   end
   if (LINE_BITS < 1 || LINE_BITS >= ADDR_W) begin : g_bad_line
      $error("rsw_coalescer: LINE_BITS out of range");
   end
   if (SEED_W < 14) begin : g_bad_seed
      $error("rsw_coalescer: SEED_W must be at least 14");
   end

   logic [SEED_W-1:0]             lfsr_q;
   logic [LANES-1:0][LANE_W-1:0]  part_gid;
   logic [LANES-1:0][LINE_W-1:0]  in_line;
   logic [LANES-1:0][LINE_W-1:0]  line_q;
   logic [LANES-1:0][LANE_W-1:0]  gid_q;
   logic [LANES-1:0]              pend_q;
   logic [LANES-1:0]              pend_next;
   logic [LANES-1:0]              sel_lanes;
   logic [LINE_W-1:0]             sel_line;
   logic                          busy_q;
   logic                          accept;

   for (genvar gl = 0; gl < LANES; gl++) begin : g_line
      assign in_line[gl] = in_addr[gl*ADDR_W + LINE_BITS +: LINE_W];
   end

   assign in_ready  = !busy_q;
   assign accept    = in_valid && in_ready;
   assign out_valid = busy_q;
   assign out_line  = sel_line;
   assign out_lanes = sel_lanes;
   assign pend_next = pend_q & ~sel_lanes;

   rsw_lfsr #(.W(SEED_W)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (seed_load),
      .step  (accept),
      .seed  (seed_value),
      .state (lfsr_q)
   );

   rsw_partition #(.LANES(LANES), .SEED_W(SEED_W)) u_part (
      .mode     (rsw_mode_e'(cfg_mode)),
      .size_log (cfg_size_log),
      .rnd      (lfsr_q),
      .gid      (part_gid)
   );

   rsw_select #(.LANES(LANES), .LINE_W(LINE_W)) u_sel (
      .pend     (pend_q),
      .gid      (gid_q),
      .line     (line_q),
      .lanes    (sel_lanes),
      .sel_line (sel_line)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done   <= 1'b0;
         pend_q <= '0;
         line_q <= '0;
         gid_q  <= '0;
      end else if (accept) begin
         line_q <= in_line;
         gid_q  <= part_gid;
         pend_q <= in_active;
         busy_q <= |in_active;
         done   <= ~|in_active;
      end else if (busy_q && out_ready) begin
         pend_q <= pend_next;
         busy_q <= |pend_next;
         done   <= ~|pend_next;
      end else begin
         done   <= 1'b0;
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_line) && $stable(out_lanes))); // R9
   AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready); // R9
   AST_LANES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_lanes & ~pend_q) == '0 && out_lanes != '0)); // R7
   AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_active == '0) |=> (done && !out_valid)); // R7
   AST_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> ($countones(pend_q) < $countones($past(pend_q)))); // R1
   AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0); // R6
endmodule

// File: tb/rsw_coalescer_tb_top.sv
module rsw_coalescer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LANES      = 32;
   localparam int ADDR_W     = 32;
   localparam int LINE_W     = 25;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [1:0]              cfg_mode = 2'd0;
   logic [2:0]              cfg_size_log = 3'd0;
   logic                    seed_load = 1'b0;
   logic [15:0]             seed_value = 16'd0;
   logic                    in_valid = 1'b0;
   logic                    in_ready;
   logic [LANES*ADDR_W-1:0] in_addr;
   logic [LANES-1:0]        in_active = '0;
   logic                    out_valid;
   logic                    out_ready = 1'b1;
   logic [LINE_W-1:0]       out_line;
   logic [LANES-1:0]        out_lanes;
   logic                    done;

   logic [31:0] addr_v [LANES];
   logic [24:0] exp_line [LANES];
   logic [31:0] exp_lanes [LANES];
   int          n_exp;
   int          n_checks = 0;
   int          n_errors = 0;
   logic [15:0] m_lfsr;
   logic [31:0] rng = 32'h1234_5678;

   for (genvar l = 0; l < LANES; l++) begin : g_addr
      assign in_addr[l*ADDR_W +: ADDR_W] = addr_v[l];
   end

   rsw_coalescer dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_size_log(cfg_size_log),
      .seed_load(seed_load), .seed_value(seed_value), .in_valid(in_valid),
      .in_ready(in_ready), .in_addr(in_addr), .in_active(in_active),
      .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line),
      .out_lanes(out_lanes), .done(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] next_rng(logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   function automatic logic [15:0] m_step(logic [15:0] s);
      return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
   endfunction

   // subwarp start for lane under the rules of R3, R4, R5
   function automatic int m_gid(int mode, int sl_in, logic [15:0] s, int lane);
      int sl, v, pos, st, node, span;
      sl = (sl_in > 5) ? 5 : sl_in;
      v  = int'(s);
      if (mode == 1) begin
         st = 0; node = 0; span = 32;
         while (span > 1 && s[node % 16]) begin
            span = span / 2;
            if (lane >= st + span) begin st = st + span; node = 2*node + 2; end
            else node = 2*node + 1;
         end
         return st;
      end else if (mode == 2) begin
         pos = (((lane ^ ((v >> 9) & 31)) * (2 * (v & 15) + 1)) + ((v >> 4) & 31)) % 32;
         return pos - (pos % (1 << sl));
      end
      return lane - (lane % (1 << sl));
   endfunction

   task automatic build_expect(input int mode, input int sl, input logic [31:0] mask);
      int gid [LANES];
      logic [31:0] pend;
      int lead;
      logic [31:0] m;
      for (int l = 0; l < LANES; l++) gid[l] = m_gid(mode, sl, m_lfsr, l);
      n_exp = 0;
      pend  = mask;
      while (pend != 0) begin
         lead = -1;
         for (int g = 0; g < LANES; g++)
            for (int l = 0; l < LANES; l++)
               if (lead < 0 && pend[l] && gid[l] == g) lead = l;
         m = '0;
         for (int l = 0; l < LANES; l++)
            if (pend[l] && gid[l] == gid[lead] && (addr_v[l] >> 7) == (addr_v[lead] >> 7))
               m[l] = 1'b1;
         exp_line[n_exp]  = 25'(addr_v[lead] >> 7);
         exp_lanes[n_exp] = m;
         pend = pend & ~m;
         n_exp++;
      end
   endtask

   // entered just after a falling edge; returns just after a falling edge
   task automatic run_instr(input int mode, input int sl, input logic [31:0] mask,
                            input bit stall, input string req, output int seen);
      build_expect(mode, sl, mask);
      seen = 0;
      cfg_mode     = 2'(mode);
      cfg_size_log = 3'(sl);
      in_active    = mask;
      in_valid     = 1'b1;
      chk(in_ready == 1'b1, "R9", "in_ready idle", 64'(in_ready), 64'd1);
      @(negedge clk);
      in_valid = 1'b0;
      m_lfsr   = m_step(m_lfsr);
      if (n_exp == 0) begin
         chk(done == 1'b1 && out_valid == 1'b0, "R7", "empty mask done/out_valid",
             64'({done, out_valid}), 64'b10);
         return;
      end
      for (int i = 0; i < n_exp; i++) begin
         chk(out_valid == 1'b1, req, "out_valid", 64'(out_valid), 64'd1);
         chk(out_line == exp_line[i], req, "out_line", 64'(out_line), 64'(exp_line[i]));
         chk(out_lanes == exp_lanes[i], req, "out_lanes", 64'(out_lanes), 64'(exp_lanes[i]));
         chk(done == 1'b0 && in_ready == 1'b0, "R9", "busy done/in_ready",
             64'({done, in_ready}), 64'b00);
         if (out_valid) seen++;
         if (stall && (i % 2 == 0)) begin
            out_ready = 1'b0;
            @(negedge clk);
            chk(out_valid && out_lanes == exp_lanes[i] && out_line == exp_line[i], "R9",
                "hold under stall", 64'(out_lanes), 64'(exp_lanes[i]));
            out_ready = 1'b1;
         end
         @(negedge clk);
      end
      chk(done == 1'b1 && out_valid == 1'b0 && in_ready == 1'b1, "R9", "end done/out_valid/in_ready",
          64'({done, out_valid, in_ready}), 64'b101);
   endtask

   task automatic set_pattern(input int pat);
      for (int l = 0; l < LANES; l++) begin
         case (pat)
            0: addr_v[l] = 32'h0000_1000;
            1: addr_v[l] = 32'h0000_2000 + 32'(4 * l);
            2: addr_v[l] = 32'h0004_0000 + 32'(128 * l);
            3: begin rng = next_rng(rng); addr_v[l] = 32'h0000_8000 + (rng & 32'h3FF); end
            default: addr_v[l] = 32'h0000_9003 + 32'(64 * l);
         endcase
      end
   endtask

   initial begin
      int seen;
      logic [31:0] mask;
      string tag;
      for (int l = 0; l < LANES; l++) addr_v[l] = '0;
      repeat (3) @(negedge clk);
      chk(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R9", "reset state",
          64'({in_ready, out_valid, done}), 64'b100);
      rst_n  = 1'b1;
      m_lfsr = 16'hACE1;
      @(negedge clk);

      // reset value of the generator drives the first random partition
      set_pattern(3);
      run_instr(2, 2, 32'hFFFF_FFFF, 1'b0, "R5/R6", seen);

      // zero seed loads 1
      seed_value = 16'h0000; seed_load = 1'b1;
      @(negedge clk);
      seed_load = 1'b0; m_lfsr = 16'h0001;
      set_pattern(4);
      run_instr(1, 0, 32'hFFFF_FFFF, 1'b0, "R4/R6", seen);

      seed_value = 16'h1D2C; seed_load = 1'b1;
      @(negedge clk);
      seed_load = 1'b0; m_lfsr = 16'h1D2C;

      // R2: same line in every lane, fixed subwarps of 8
      set_pattern(0);
      run_instr(0, 3, 32'hFFFF_FFFF, 1'b0, "R2", seen);
      chk(seen == 4, "R2", "request count", 64'(seen), 64'd4);
      run_instr(0, 1, 32'hFFFF_FFFF, 1'b1, "R2", seen);
      chk(seen == 16, "R2", "request count", 64'(seen), 64'd16);

      // R7: empty masks, back to back
      run_instr(1, 0, 32'h0, 1'b0, "R7", seen);
      run_instr(2, 3, 32'h0, 1'b0, "R7", seen);

      // spare mode code behaves as fixed
      set_pattern(3);
      run_instr(3, 2, 32'hFFFF_FFFF, 1'b1, "R3", seen);
      run_instr(0, 7, 32'hFFFF_FFFF, 1'b0, "R3", seen);

      for (int mode = 0; mode < 3; mode++)
         for (int sl = 0; sl < 6; sl++)
            for (int pat = 0; pat < 5; pat++)
               for (int mv = 0; mv < 3; mv++) begin
                  set_pattern(pat);
                  rng = next_rng(rng);
                  case (mv)
                     0: mask = 32'hFFFF_FFFF;
                     1: mask = 32'h5A5A_A5A5;
                     default: mask = rng | 32'h0001_0000;
                  endcase
                  case (mode)
                     0: tag = "R1/R3/R8";
                     1: tag = "R1/R4/R6/R8";
                     default: tag = "R1/R5/R6/R8";
                  endcase
                  if (mv != 0) tag = {tag, "/R7"};
                  run_instr(mode, sl, mask, ((pat + mv) % 2) == 1, tag, seen);
               end

      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule